// File: doc/BRIEF.md
# Protected-Mode Segment Register Load Checker

This block takes one request at a time to load a segment register: the stack register or one of four data registers. Each request carries a selector, the current privilege level and the descriptor table limit. Checks that need only the selector run first. If they pass, the block fetches the 8-byte descriptor over a request/response memory port and checks its access-rights byte. Every request ends in one of two ways. Either the selector and descriptor are committed to the target register, or a single fault is reported with its class and error code.

The checks run in a fixed priority order, and that order differs between the stack register and the data registers. A successful stack load also raises an interrupt-inhibit flag. The flag stays set until the next instruction retires. A read port shows the selector, cached descriptor and valid bit of any register.

Top module: `seg_load_checker`

## Requirements
- R1: A selector with bits 15:2 all zero is null. A null load into a data register (DS=1, ES=2, FS=3, GS=4) commits without a memory fetch. It stores the selector and clears that register's descriptor-valid bit.
- R2: A null load into the stack register (code 0) reports fault class GP (1) with error code 0 and makes no fetch.
- R3: A selector passes the limit check only when {bits 15:3, 3'b111} is less than or equal to the table limit. On failure, class GP is reported with the selector as code, and no fetch is made.
- R4: For the stack register, an RPL (selector bits 1:0) that differs from CPL raises GP(selector) before any fetch.
- R5: For the stack register, the access-rights byte (descriptor bits 47:40) must describe a writable data segment: bit 4 set, bit 3 clear, bit 1 set. Its DPL (bits 6:5) must then equal CPL. Each failure raises GP(selector), and both are tested before presence.
- R6: A stack segment with the present bit (bit 7) clear raises class STACK (2) with the selector as code.
- R7: For data registers, the descriptor must be data (bit 4 set, bit 3 clear) or readable code (bits 4, 3 and 1 set). Otherwise GP(selector) is raised.
- R8: For data registers, when the segment is data or non-conforming code (bit 2 clear), both RPL and CPL must be at most DPL, else GP(selector). Conforming code skips this test. It is tested before presence.
- R9: A data register whose segment is not present raises class NOT-PRESENT (3) with the selector as code.
- R10: A successful fetched load writes the selector and the full 64-bit descriptor, and sets the valid bit. The read port shows them.
- R11: A fault leaves the target register unchanged.
- R12: Each accepted request yields exactly one done pulse, carrying either commit or fault_valid. The memory request holds until accepted, and carries offset {selector bits 15:3, 3'b000} and the table bit (selector bit 2).
- R13: int_inhibit is set by a committed stack load and cleared by the next retire pulse. Faults and data-register loads never set it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Load request present |
| req_ready | output | 1 | Block idle, request accepted |
| req_seg | input | 3 | Target register code |
| req_sel | input | 16 | Selector to load |
| req_cpl | input | 2 | Current privilege level |
| req_limit | input | 16 | Descriptor table limit |
| mem_req_valid | output | 1 | Descriptor read request |
| mem_req_ready | input | 1 | Memory accepts read |
| mem_req_offset | output | 16 | Byte offset of descriptor in table |
| mem_req_ldt | output | 1 | Table select bit from selector |
| mem_resp_valid | input | 1 | Descriptor data returned |
| mem_resp_data | input | 64 | Descriptor contents |
| done | output | 1 | One-cycle completion pulse |
| commit | output | 1 | Load committed |
| fault_valid | output | 1 | Load faulted |
| fault_class | output | 2 | 0 none, 1 GP, 2 STACK, 3 NOT-PRESENT |
| fault_code | output | 16 | Error code |
| retire | input | 1 | Instruction-retire pulse |
| int_inhibit | output | 1 | Interrupts held off |
| rd_seg | input | 3 | Register selected for readback |
| rd_sel | output | 16 | Stored selector |
| rd_desc | output | 64 | Cached descriptor |
| rd_dvalid | output | 1 | Descriptor-valid bit |

## Verification
The hardest cases to reach are those where several checks fail at once. Only the first failure in priority order may be reported. From the ports this is visible only as the fault class and code. Vectors therefore combine failures deliberately: a non-present read-only stack segment, and a non-present data segment whose RPL exceeds DPL. These prove that type and privilege win over presence. The limit check is probed on both sides of its exact boundary, and register contents are read back after every fault to show they were untouched.

// File: rtl/seg_chk_pkg.sv
`timescale 1ns/1ps
// Shared types for the segment load checker.
// Assumes a 5-register target set and an 8-bit access-rights byte.
package seg_chk_pkg;
    localparam int SEG_ID_W = 3;

    typedef enum logic [2:0] {
        SEG_SS = 3'd0,
        SEG_DS = 3'd1,
        SEG_ES = 3'd2,
        SEG_FS = 3'd3,
        SEG_GS = 3'd4
    } seg_id_e;

    typedef enum logic [1:0] {
        FLT_NONE = 2'd0,
        FLT_GP   = 2'd1,
        FLT_STK  = 2'd2,
        FLT_NP   = 2'd3
    } flt_class_e;

    // Access-rights byte, MSB first.
    typedef struct packed {
        logic       present;
        logic [1:0] dpl;
        logic       code_data;
        logic       is_code;
        logic       conform;
        logic       rw;
        logic       accessed;
    } ar_t;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_MREQ  = 3'd2,
        ST_MRESP = 3'd3,
        ST_POST  = 3'd4
    } fsm_e;
endpackage

// File: rtl/seg_pre_check.sv
`timescale 1ns/1ps
// Selector-only checks that run before any descriptor fetch: null
// detection, table limit and (stack only) RPL against CPL.
// Assumes the selector layout index/table-bit/RPL, with the index at the top.
module seg_pre_check #(
    parameter int SEL_W = 16
) (
    input  logic             is_stack,
    input  logic [SEL_W-1:0] sel,
    input  logic [1:0]       cpl,
    input  logic [SEL_W-1:0] tbl_limit,
    output logic             fault,
    output logic [SEL_W-1:0] fault_code,
    output logic             skip_fetch
);
    logic null_sel;
    logic limit_ok;
    logic rpl_ok;

    // Decode the three selector-only conditions.
    always_comb begin
        null_sel = (sel[SEL_W-1:2] == '0);
        limit_ok = ({sel[SEL_W-1:3], 3'b111} <= tbl_limit);
        rpl_ok   = (sel[1:0] == cpl);
    end

    // Apply the register-dependent priority order.
    always_comb begin
        fault      = 1'b0;
        fault_code = '0;
        skip_fetch = 1'b0;
        if (is_stack) begin
            if (null_sel) begin
                fault      = 1'b1;
                fault_code = '0;
            end else if (!limit_ok || !rpl_ok) begin
                fault      = 1'b1;
                fault_code = sel;
            end
        end else begin
            if (null_sel) begin
                skip_fetch = 1'b1;
            end else if (!limit_ok) begin
                fault      = 1'b1;
                fault_code = sel;
            end
        end
    end
endmodule

// File: rtl/seg_post_check.sv
`timescale 1ns/1ps
// Descriptor checks applied after the fetch: type, privilege, presence.
// Assumes the access-rights byte layout of seg_chk_pkg::ar_t.
module seg_post_check
    import seg_chk_pkg::*;
(
    input  logic       is_stack,
    input  logic [1:0] rpl,
    input  logic [1:0] cpl,
    input  logic [7:0] ar_byte,
    output logic       fault,
    output flt_class_e fclass
);
    ar_t  ar;
    logic is_data;
    logic is_code;
    logic unused_acc;

    // Split the access-rights byte into segment kinds.
    always_comb begin
        ar         = ar_t'(ar_byte);
        is_data    = ar.code_data && !ar.is_code;
        is_code    = ar.code_data && ar.is_code;
        unused_acc = ar.accessed;
    end

    // Priority-ordered checks; the first failure wins.
    always_comb begin
        fault  = 1'b0;
        fclass = FLT_NONE;
        if (is_stack) begin
            if (!(is_data && ar.rw)) begin
                fault = 1'b1; fclass = FLT_GP;
            end else if (ar.dpl != cpl) begin
                fault = 1'b1; fclass = FLT_GP;
            end else if (!ar.present) begin
                fault = 1'b1; fclass = FLT_STK;
            end
        end else begin
            if (!(is_data || (is_code && ar.rw))) begin
                fault = 1'b1; fclass = FLT_GP;
            end else if ((is_data || !ar.conform) &&
                         ((rpl > ar.dpl) || (cpl > ar.dpl))) begin
                fault = 1'b1; fclass = FLT_GP;
            end else if (!ar.present) begin
                fault = 1'b1; fclass = FLT_NP;
            end
        end
    end
endmodule

// File: rtl/seg_reg_bank.sv
`timescale 1ns/1ps
// Segment register storage: selector, cached descriptor and valid bit per
// register, with one write port and one combinational read port.
// Assumes register codes 0..NUM_SEG-1; other codes read as zero.
module seg_reg_bank
    import seg_chk_pkg::*;
#(
    parameter int NUM_SEG = 5,
    parameter int SEL_W   = 16,
    parameter int DESC_W  = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [SEG_ID_W-1:0] wr_idx,
    input  logic [SEL_W-1:0]    wr_sel,
    input  logic [DESC_W-1:0]   wr_desc,
    input  logic                wr_dvalid,
    input  logic [SEG_ID_W-1:0] rd_idx,
    output logic [SEL_W-1:0]    rd_sel,
    output logic [DESC_W-1:0]   rd_desc,
    output logic                rd_dvalid
);
    logic [SEL_W-1:0]  sel_all  [NUM_SEG];
    logic [DESC_W-1:0] desc_all [NUM_SEG];
    logic              val_all  [NUM_SEG];

    for (genvar g = 0; g < NUM_SEG; g++) begin : g_reg
        logic [SEL_W-1:0]  sel_r;
        logic [DESC_W-1:0] desc_r;
        logic              val_r;

        // Capture a write aimed at this register; a null load keeps the old descriptor.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                sel_r  <= '0;
                desc_r <= '0;
                val_r  <= 1'b0;
            end else if (wr_en && (wr_idx == SEG_ID_W'(g))) begin
                sel_r <= wr_sel;
                val_r <= wr_dvalid;
                if (wr_dvalid) desc_r <= wr_desc;
            end
        end

        assign sel_all[g]  = sel_r;
        assign desc_all[g] = desc_r;
        assign val_all[g]  = val_r;
    end

    // Select the register named on the read port.
    always_comb begin
        rd_sel    = '0;
        rd_desc   = '0;
        rd_dvalid = 1'b0;
        for (int i = 0; i < NUM_SEG; i++) begin
            if (rd_idx == SEG_ID_W'(i)) begin
                rd_sel    = sel_all[i];
                rd_desc   = desc_all[i];
                rd_dvalid = val_all[i];
            end
        end
    end

    // R1
    null_clears_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_dvalid) |-> (wr_sel[SEL_W-1:2] == '0));
endmodule

// File: rtl/seg_load_checker.sv
`timescale 1ns/1ps
// Segment register load checker. Accepts one load at a time, runs the
// selector checks, fetches the descriptor, runs the descriptor checks and
// then commits or reports one fault. Sets an interrupt-inhibit flag after a
// committed stack load. Assumes the memory answers every accepted read.
module seg_load_checker
    import seg_chk_pkg::*;
#(
    parameter int NUM_SEG = 5,
    parameter int SEL_W   = 16,
    parameter int DESC_W  = 64,
    parameter int AR_LSB  = 40
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [SEG_ID_W-1:0] req_seg,
    input  logic [SEL_W-1:0]    req_sel,
    input  logic [1:0]          req_cpl,
    input  logic [SEL_W-1:0]    req_limit,
    output logic                mem_req_valid,
    input  logic                mem_req_ready,
    output logic [SEL_W-1:0]    mem_req_offset,
    output logic                mem_req_ldt,
    input  logic                mem_resp_valid,
    input  logic [DESC_W-1:0]   mem_resp_data,
    output logic                done,
    output logic                commit,
    output logic                fault_valid,
    output logic [1:0]          fault_class,
    output logic [SEL_W-1:0]    fault_code,
    input  logic                retire,
    output logic                int_inhibit,
    input  logic [SEG_ID_W-1:0] rd_seg,
    output logic [SEL_W-1:0]    rd_sel,
    output logic [DESC_W-1:0]   rd_desc,
    output logic                rd_dvalid
);
    fsm_e               state;
    logic [SEG_ID_W-1:0] q_seg;
    logic [SEL_W-1:0]   q_sel;
    logic [1:0]         q_cpl;
    logic [SEL_W-1:0]   q_limit;
    logic [DESC_W-1:0]  q_desc;

    logic               is_stack;
    logic               pre_fault;
    logic [SEL_W-1:0]   pre_code;
    logic               pre_skip;
    logic               post_fault;
    flt_class_e         post_class;
    logic               wr_en;
    logic               wr_dvalid;

    assign is_stack = (q_seg == SEG_SS);

    seg_pre_check #(.SEL_W(SEL_W)) u_pre (
        .is_stack   (is_stack),
        .sel        (q_sel),
        .cpl        (q_cpl),
        .tbl_limit  (q_limit),
        .fault      (pre_fault),
        .fault_code (pre_code),
        .skip_fetch (pre_skip)
    );

    seg_post_check u_post (
        .is_stack (is_stack),
        .rpl      (q_sel[1:0]),
        .cpl      (q_cpl),
        .ar_byte  (q_desc[AR_LSB +: 8]),
        .fault    (post_fault),
        .fclass   (post_class)
    );

    // Register-file write strobe for both commit paths.
    always_comb begin
        wr_en     = ((state == ST_PRE) && !pre_fault && pre_skip) ||
                    ((state == ST_POST) && !post_fault);
        wr_dvalid = (state == ST_POST);
    end

    seg_reg_bank #(.NUM_SEG(NUM_SEG), .SEL_W(SEL_W), .DESC_W(DESC_W)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (q_seg),
        .wr_sel    (q_sel),
        .wr_desc   (q_desc),
        .wr_dvalid (wr_dvalid),
        .rd_idx    (rd_seg),
        .rd_sel    (rd_sel),
        .rd_desc   (rd_desc),
        .rd_dvalid (rd_dvalid)
    );

    assign req_ready      = (state == ST_IDLE);
    assign mem_req_valid  = (state == ST_MREQ);
    assign mem_req_offset = {q_sel[SEL_W-1:3], 3'b000};
    assign mem_req_ldt    = q_sel[2];

    // Sequencer: accept, pre-check, fetch, post-check, report.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            q_seg       <= '0;
            q_sel       <= '0;
            q_cpl       <= '0;
            q_limit     <= '0;
            q_desc      <= '0;
            done        <= 1'b0;
            commit      <= 1'b0;
            fault_valid <= 1'b0;
            fault_class <= FLT_NONE;
            fault_code  <= '0;
        end else begin
            done        <= 1'b0;
            commit      <= 1'b0;
            fault_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        q_seg   <= req_seg;
                        q_sel   <= req_sel;
                        q_cpl   <= req_cpl;
                        q_limit <= req_limit;
                        state   <= ST_PRE;
                    end
                end
                ST_PRE: begin
                    if (pre_fault) begin
                        done        <= 1'b1;
                        fault_valid <= 1'b1;
                        fault_class <= FLT_GP;
                        fault_code  <= pre_code;
                        state       <= ST_IDLE;
                    end else if (pre_skip) begin
                        done        <= 1'b1;
                        commit      <= 1'b1;
                        fault_class <= FLT_NONE;
                        fault_code  <= '0;
                        state       <= ST_IDLE;
                    end else begin
                        state <= ST_MREQ;
                    end
                end
                ST_MREQ: begin
                    if (mem_req_ready) state <= ST_MRESP;
                end
                ST_MRESP: begin
                    if (mem_resp_valid) begin
                        q_desc <= mem_resp_data;
                        state  <= ST_POST;
                    end
                end
                ST_POST: begin
                    done <= 1'b1;
                    if (post_fault) begin
                        fault_valid <= 1'b1;
                        fault_class <= post_class;
                        fault_code  <= q_sel;
                    end else begin
                        commit      <= 1'b1;
                        fault_class <= FLT_NONE;
                        fault_code  <= '0;
                    end
                    state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Interrupt inhibit: a stack commit sets it, the next retire clears it.
    always_ff @(posedge clk) begin
        if (!rst_n)                   int_inhibit <= 1'b0;
        else if (wr_en && is_stack)   int_inhibit <= 1'b1;
        else if (retire)              int_inhibit <= 1'b0;
    end

    // R12
    done_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (commit ^ fault_valid));
    // R12
    mem_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> mem_req_valid);
    // R12
    one_at_a_time_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);
    // R13
    ss_inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (q_seg == SEG_SS)) |-> int_inhibit);
    // R6
    stack_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && (fault_class == FLT_STK)) |-> (q_seg == SEG_SS));
    // R9
    np_class_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_valid && (fault_class == FLT_NP)) |-> (q_seg != SEG_SS));
endmodule

// File: tb/seg_load_checker_tb.sv
`timescale 1ns/1ps
module seg_load_checker_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid, req_ready;
    logic [2:0]  req_seg;
    logic [15:0] req_sel, req_limit;
    logic [1:0]  req_cpl;
    logic        mem_req_valid, mem_req_ready, mem_req_ldt, mem_resp_valid;
    logic [15:0] mem_req_offset;
    logic [63:0] mem_resp_data;
    logic        done, commit, fault_valid, retire, int_inhibit;
    logic [1:0]  fault_class;
    logic [15:0] fault_code;
    logic [2:0]  rd_seg;
    logic [15:0] rd_sel;
    logic [63:0] rd_desc;
    logic        rd_dvalid;

    int tests = 0;
    int fails = 0;
    int fetch_cnt = 0;
    logic [15:0] last_off;
    logic        last_ldt;
    logic [63:0] cur_desc;

    always #4 clk = ~clk;

    seg_load_checker u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_seg(req_seg),
        .req_sel(req_sel), .req_cpl(req_cpl), .req_limit(req_limit),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_offset(mem_req_offset), .mem_req_ldt(mem_req_ldt),
        .mem_resp_valid(mem_resp_valid), .mem_resp_data(mem_resp_data),
        .done(done), .commit(commit), .fault_valid(fault_valid),
        .fault_class(fault_class), .fault_code(fault_code),
        .retire(retire), .int_inhibit(int_inhibit),
        .rd_seg(rd_seg), .rd_sel(rd_sel), .rd_desc(rd_desc), .rd_dvalid(rd_dvalid)
    );

    task automatic check(input logic [63:0] act, input logic [63:0] exp, input string req);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Memory model: one-cycle ready, response two cycles later.
    initial begin
        mem_req_ready  = 1'b0;
        mem_resp_valid = 1'b0;
        mem_resp_data  = '0;
        forever begin
            @(negedge clk);
            if (mem_req_valid && !mem_req_ready) begin
                mem_req_ready = 1'b1;
                fetch_cnt++;
                last_off = mem_req_offset;
                last_ldt = mem_req_ldt;
                @(negedge clk);
                mem_req_ready = 1'b0;
                @(negedge clk);
                mem_resp_valid = 1'b1;
                mem_resp_data  = cur_desc;
                @(negedge clk);
                mem_resp_valid = 1'b0;
            end
        end
    end

    // Vector: seg3 sel16 cpl2 lim16 ar8 | commit1 class2 code16 fetch1
    localparam int NV = 20;
    localparam logic [64:0] VEC [NV] = '{
        {3'd0,16'h0010,2'd0,16'h00FF,8'h92, 1'b1,2'd0,16'h0000,1'b1}, // R10 R13 SS ok
        {3'd0,16'h0002,2'd0,16'h00FF,8'h92, 1'b0,2'd1,16'h0000,1'b0}, // R2 SS null
        {3'd0,16'h0108,2'd0,16'h00FF,8'h92, 1'b0,2'd1,16'h0108,1'b0}, // R3 over limit
        {3'd0,16'h0011,2'd0,16'h00FF,8'h92, 1'b0,2'd1,16'h0011,1'b0}, // R4 RPL!=CPL
        {3'd0,16'h0010,2'd0,16'h00FF,8'h90, 1'b0,2'd1,16'h0010,1'b1}, // R5 read-only
        {3'd0,16'h0013,2'd3,16'h00FF,8'h92, 1'b0,2'd1,16'h0013,1'b1}, // R5 DPL!=CPL
        {3'd0,16'h0010,2'd0,16'h00FF,8'h12, 1'b0,2'd2,16'h0010,1'b1}, // R6 not present
        {3'd0,16'h0010,2'd0,16'h00FF,8'h10, 1'b0,2'd1,16'h0010,1'b1}, // R5 type before present
        {3'd1,16'h0003,2'd0,16'h00FF,8'h92, 1'b1,2'd0,16'h0000,1'b0}, // R1 DS null
        {3'd1,16'h0108,2'd0,16'h00FF,8'h92, 1'b0,2'd1,16'h0108,1'b0}, // R3 DS limit
        {3'd1,16'h0018,2'd0,16'h00FF,8'h98, 1'b0,2'd1,16'h0018,1'b1}, // R7 exec-only code
        {3'd2,16'h001C,2'd0,16'h00FF,8'h9A, 1'b1,2'd0,16'h0000,1'b1}, // R10 R12 ES readable code, table bit
        {3'd3,16'h0023,2'd3,16'h00FF,8'h92, 1'b0,2'd1,16'h0023,1'b1}, // R8 RPL>DPL
        {3'd4,16'h0020,2'd3,16'h00FF,8'h92, 1'b0,2'd1,16'h0020,1'b1}, // R8 CPL>DPL
        {3'd4,16'h0023,2'd0,16'h00FF,8'h9E, 1'b1,2'd0,16'h0000,1'b1}, // R8 conforming skips
        {3'd1,16'h0028,2'd0,16'h00FF,8'h12, 1'b0,2'd3,16'h0028,1'b1}, // R9 not present
        {3'd1,16'h002B,2'd0,16'h00FF,8'h10, 1'b0,2'd1,16'h002B,1'b1}, // R8 privilege before present
        {3'd2,16'h0030,2'd0,16'h00FF,8'h82, 1'b0,2'd1,16'h0030,1'b1}, // R7 system descriptor
        {3'd3,16'h00F8,2'd3,16'h00FF,8'hF2, 1'b1,2'd0,16'h0000,1'b1}, // R3 R10 limit edge passes
        {3'd0,16'h00F8,2'd0,16'h00FE,8'h92, 1'b0,2'd1,16'h00F8,1'b0}  // R3 limit edge fails
    };

    logic [15:0] sh_sel  [5];
    logic [63:0] sh_desc [5];
    logic        sh_val  [5];

    task automatic pulse_retire();
        @(negedge clk); retire = 1'b1;
        @(negedge clk); retire = 1'b0;
    endtask

    task automatic do_load(input logic [2:0] s, input logic [15:0] sl,
                           input logic [1:0] c, input logic [15:0] lm);
        @(negedge clk);
        req_valid = 1'b1; req_seg = s; req_sel = sl; req_cpl = c; req_limit = lm;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 40; k++) begin
            if (done) break;
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        rst_n = 1'b0; req_valid = 1'b0; req_seg = '0; req_sel = '0;
        req_cpl = '0; req_limit = '0; retire = 1'b0; rd_seg = '0; cur_desc = '0;
        for (int i = 0; i < 5; i++) begin sh_sel[i] = '0; sh_desc[i] = '0; sh_val[i] = 1'b0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R12, R13)
        check(req_ready, 1, "R12 reset ready");
        check(done, 0, "R12 reset done");
        check(mem_req_valid, 0, "R12 reset mem");
        check(int_inhibit, 0, "R13 reset inhibit");
        check(rd_dvalid, 0, "R10 reset valid");

        for (int v = 0; v < NV; v++) begin
            logic [2:0]  s;  logic [15:0] sl; logic [1:0] c; logic [15:0] lm;
            logic [7:0]  ar; logic ec; logic [1:0] ecl; logic [15:0] eco; logic ef;
            int f0;
            {s, sl, c, lm, ar, ec, ecl, eco, ef} = VEC[v];
            pulse_retire();
            cur_desc = {16'h00C0, ar, 8'h00, 16'(v * 16'h1111), 16'hFFFF};
            f0 = fetch_cnt;
            do_load(s, sl, c, lm);
            check(done, 1, "R12 done pulse");
            check(commit, ec, "R10 commit");
            check(fault_valid, !ec, "R11 fault flag");
            check(fault_class, ecl, "R2 R5 R6 R9 class");
            check(fault_code, eco, "R3 R4 code");
            check(fetch_cnt - f0, ef, "R1 R2 R3 fetch");
            check(int_inhibit, (ec && s == 3'd0), "R13 inhibit");
            if (ef) begin
                check(last_off, {sl[15:3], 3'b000}, "R12 offset");
                check(last_ldt, sl[2], "R12 table bit");
            end
            if (ec) begin
                sh_sel[s] = sl;
                sh_val[s] = ef;
                if (ef) sh_desc[s] = cur_desc;
            end
            rd_seg = s;
            @(negedge clk);
            check(done, 0, "R12 single pulse");
            check(rd_sel, sh_sel[s], "R10 R11 selector");
            check(rd_dvalid, sh_val[s], "R1 R11 valid");
            check(rd_desc, sh_desc[s], "R10 R11 descriptor");
        end

        // R13: inhibit survives idle cycles, clears on retire
        pulse_retire();
        cur_desc = {16'h00C0, 8'h92, 40'h0};
        do_load(3'd0, 16'h0008, 2'd0, 16'h00FF);
        repeat (3) @(negedge clk);
        check(int_inhibit, 1, "R13 held until retire");
        pulse_retire();
        check(int_inhibit, 0, "R13 cleared by retire");

        // R1: null into ES after a fetched load clears only the valid bit
        do_load(3'd2, 16'h0001, 2'd0, 16'h00FF);
        rd_seg = 3'd2;
        @(negedge clk);
        check(rd_sel, 16'h0001, "R1 null selector stored");
        check(rd_dvalid, 0, "R1 null clears valid");

        // Reset clears stored state
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        rd_seg = 3'd0;
        @(negedge clk);
        check(rd_dvalid, 0, "R10 valid after reset");
        check(int_inhibit, 0, "R13 inhibit after reset");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule